// File: doc/BRIEF.md
# Digital PI Current Regulator

This block closes a discrete current loop once per control tick. Each time the tick strobe is raised it captures a commanded current, a measured current, a feedforward term, the two loop gains, a run-time clamp limit and a protection freeze flag. From these it forms a current error, a proportional term, an integral term and the feedforward sum. The result is a bounded drive word for a downstream DAC or PWM stage.

The drive is limited symmetrically to the smaller of a fixed hardware ceiling and a limit supplied by a derating controller. While the drive sits at that limit, the integrator is kept from winding up. The protection logic can also freeze the integrator when feedback cannot be trusted. The latency from tick to result is the same in every case, so the delay inside the loop can be budgeted exactly.

Top module: `pi_current_reg`

## Requirements
- R1: The error is cmd_i minus meas_i. With ki_i = 0 and ff_i = 0 the unclamped output is floor(kp_i * error / 256), where kp_i is an unsigned gain with 8 fractional bits.
- R2: ff_i is added, as a signed value, to the proportional and integral terms before clamping.
- R3: Each accepted tick adds ki_i * error to a signed 32-bit accumulator. The tick's output uses floor(acc / 256), taken from the accumulator value before that tick's own update.
- R4: The drive is clamped to ±L, where L = min(clamp_lim_i, HW_LIMIT) and HW_LIMIT defaults to 32767. sat_o is 1 exactly when the unclamped sum lies outside ±L.
- R5: clamp_lim_i takes effect on the tick at which it is presented. A limit of 0 forces the drive to 0 with sat_o = 1.
- R6: In the default mode, when the unclamped sum is above +L a positive error leaves the accumulator unchanged and a negative error is accumulated. When the sum is below −L the rule is mirrored.
- R7: With freeze_i = 1 at a tick, the accumulator keeps its value.
- R8: A synchronous active-high rst_i clears the accumulator and sets drive_o = 0, sat_o = 0 and valid_o = 0.
- R9: The accumulator saturates at 2^31−1 and −2^31 instead of wrapping.
- R10: valid_o is high for one cycle, exactly two clock edges after each edge at which sample_i is high. This also holds for ticks on consecutive cycles.
- R11: While sample_i is low, input changes are ignored: drive_o and sat_o hold and the accumulator does not change.
- R12: With AW_MODE set to the hard-stop variant, any saturated tick leaves the accumulator unchanged, whatever the sign of the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Control tick strobe |
| cmd_i | input | 16 | Commanded current, signed |
| meas_i | input | 16 | Measured current, signed |
| ff_i | input | 16 | Feedforward term, signed |
| kp_i | input | 16 | Proportional gain, unsigned, 8 fractional bits |
| ki_i | input | 16 | Integral gain, unsigned, 8 fractional bits |
| clamp_lim_i | input | 15 | Run-time magnitude limit from derating |
| freeze_i | input | 1 | Hold the integrator at this tick |
| drive_o | output | 16 | Clamped drive command, signed |
| sat_o | output | 1 | Drive was clamped at the last tick |
| valid_o | output | 1 | New drive_o is available |

## Verification
Each tick's drive_o, sat_o and valid_o are due two rising edges after the edge that sees sample_i. The accumulator update caused by a tick first shows up in the drive of the following tick. The bench raises sample_i at a falling edge and checks that valid_o is low one falling edge later. It then compares the outputs at the second falling edge, and for back-to-back ticks it reads one result per falling edge in order. A reference model in the bench, built from the requirements, tracks the accumulator for both anti-windup variants. Tests that cover hidden state, such as freeze, windup and accumulator saturation, finish with a probe tick at zero error and no feedforward, so that floor(acc/256) appears directly on drive_o.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;

   // Anti-windup policy chosen at elaboration time
   typedef enum logic [0:0] {
      AW_COND = 1'b0,   // integrate only when the error pulls back toward the linear region
      AW_STOP = 1'b1    // integrate never while saturated
   } aw_mode_e;

endpackage

// File: rtl/pi_sample_stage.sv
module pi_sample_stage #(
   parameter int DATA_W   = 16,
   parameter int GAIN_W   = 16,
   parameter int HW_LIMIT = 32767,
   localparam int ERR_W   = DATA_W + 1,
   localparam int LIM_W   = DATA_W - 1
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     sample_i,
   input  logic signed [DATA_W-1:0] cmd_i,
   input  logic signed [DATA_W-1:0] meas_i,
   input  logic signed [DATA_W-1:0] ff_i,
   input  logic [GAIN_W-1:0]        kp_i,
   input  logic [GAIN_W-1:0]        ki_i,
   input  logic [LIM_W-1:0]         clamp_lim_i,
   input  logic                     freeze_i,
   output logic                     s1_vld_o,
   output logic signed [ERR_W-1:0]  err_o,
   output logic signed [DATA_W-1:0] ff_o,
   output logic [GAIN_W-1:0]        kp_o,
   output logic [GAIN_W-1:0]        ki_o,
   output logic [LIM_W-1:0]         lim_o,
   output logic                     frz_o
);

   localparam logic [LIM_W-1:0] HW_LIM_V = LIM_W'(HW_LIMIT);

   logic signed [ERR_W-1:0] err_d;
   logic [LIM_W-1:0]        lim_d;

   always_comb begin
      err_d = ERR_W'(cmd_i) - ERR_W'(meas_i);
      lim_d = (clamp_lim_i < HW_LIM_V) ? clamp_lim_i : HW_LIM_V;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         s1_vld_o <= 1'b0;
         err_o    <= '0;
         ff_o     <= '0;
         kp_o     <= '0;
         ki_o     <= '0;
         lim_o    <= '0;
         frz_o    <= 1'b0;
      end else begin
         s1_vld_o <= sample_i;
         if (sample_i) begin
            err_o <= err_d;
            ff_o  <= ff_i;
            kp_o  <= kp_i;
            ki_o  <= ki_i;
            lim_o <= lim_d;
            frz_o <= freeze_i;
         end
      end
   end

   AST_LIM_NOT_ABOVE_HW: assert property (@(posedge clk_i) disable iff (rst_i)
      s1_vld_o |-> (lim_o <= HW_LIM_V));                                  // R4

   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
      !sample_i |=> ($stable(err_o) && $stable(lim_o) && $stable(frz_o))); // R11

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
   import pi_reg_pkg::*;
#(
   parameter int       ERR_W   = 17,
   parameter int       GAIN_W  = 16,
   parameter int       ACC_W   = 32,
   parameter aw_mode_e AW_MODE = AW_COND,
   localparam int      PROD_W  = ERR_W + GAIN_W + 1,
   localparam int      SUMI_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    upd_i,
   input  logic signed [ERR_W-1:0] err_i,
   input  logic [GAIN_W-1:0]       ki_i,
   input  logic                    frz_i,
   input  logic                    over_hi_i,
   input  logic                    over_lo_i,
   output logic signed [ACC_W-1:0] acc_o
);

   logic signed [GAIN_W:0]    ki_s;
   logic signed [PROD_W-1:0]  inc;
   logic signed [SUMI_W-1:0]  nxt_raw;
   logic signed [ACC_W-1:0]   nxt_sat;
   logic                      fits;
   logic                      err_pos;
   logic                      err_neg;
   logic                      blk;
   logic                      hold;

   always_comb begin
      ki_s    = $signed({1'b0, ki_i});
      inc     = PROD_W'(ki_s) * PROD_W'(err_i);
      nxt_raw = SUMI_W'(acc_o) + SUMI_W'(inc);
      // value fits when all bits above the target sign bit agree with it
      fits    = (nxt_raw[SUMI_W-1:ACC_W-1] == '0) || (nxt_raw[SUMI_W-1:ACC_W-1] == '1);
      if (fits)
         nxt_sat = nxt_raw[ACC_W-1:0];
      else if (nxt_raw[SUMI_W-1])
         nxt_sat = {1'b1, {(ACC_W-1){1'b0}}};
      else
         nxt_sat = {1'b0, {(ACC_W-1){1'b1}}};
      err_neg = err_i[ERR_W-1];
      err_pos = !err_i[ERR_W-1] && (err_i != '0);
   end

   generate
      if (AW_MODE == AW_COND) begin : g_aw_cond
         assign blk = (over_hi_i && err_pos) || (over_lo_i && err_neg);

         AST_RELEASE_HI: assert property (@(posedge clk_i) disable iff (rst_i)
            (upd_i && !frz_i && over_hi_i && err_neg && !$isunknown(ki_i) && ki_i != '0)
               |=> (acc_o < $past(acc_o) || acc_o == {1'b1, {(ACC_W-1){1'b0}}}));  // R6
      end else begin : g_aw_stop
         assign blk = over_hi_i || over_lo_i;

         AST_STOP_WHEN_SAT: assert property (@(posedge clk_i) disable iff (rst_i)
            (upd_i && (over_hi_i || over_lo_i)) |=> $stable(acc_o));            // R12
      end
   endgenerate

   assign hold = frz_i || blk;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         acc_o <= '0;
      else if (upd_i && !hold)
         acc_o <= nxt_sat;
   end

   AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (upd_i && frz_i) |=> $stable(acc_o));                                    // R7

   AST_NO_WINDUP_HI: assert property (@(posedge clk_i) disable iff (rst_i)
      (upd_i && over_hi_i && err_pos) |=> $stable(acc_o));                     // R6

   AST_NO_WINDUP_LO: assert property (@(posedge clk_i) disable iff (rst_i)
      (upd_i && over_lo_i && err_neg) |=> $stable(acc_o));                     // R6

   AST_NO_WRAP_UP: assert property (@(posedge clk_i) disable iff (rst_i)
      (upd_i && !inc[PROD_W-1]) |=> (acc_o >= $past(acc_o)));                  // R9

   AST_NO_WRAP_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
      (upd_i && inc[PROD_W-1]) |=> (acc_o <= $past(acc_o)));                   // R9

   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !upd_i |=> $stable(acc_o));                                              // R11

endmodule

// File: rtl/pi_output_stage.sv
module pi_output_stage #(
   parameter int  DATA_W = 16,
   parameter int  GAIN_W = 16,
   parameter int  FRAC_W = 8,
   parameter int  ACC_W  = 32,
   localparam int ERR_W  = DATA_W + 1,
   localparam int LIM_W  = DATA_W - 1,
   localparam int PROD_W = ERR_W + GAIN_W + 1,
   localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     upd_i,
   input  logic signed [ERR_W-1:0]  err_i,
   input  logic [GAIN_W-1:0]        kp_i,
   input  logic signed [DATA_W-1:0] ff_i,
   input  logic [LIM_W-1:0]         lim_i,
   input  logic signed [ACC_W-1:0]  acc_i,
   output logic                     over_hi_o,
   output logic                     over_lo_o,
   output logic signed [DATA_W-1:0] drive_o,
   output logic                     sat_o,
   output logic                     valid_o
);

   logic signed [GAIN_W:0]   kp_s;
   logic signed [PROD_W-1:0] p_prod;
   logic signed [PROD_W-1:0] p_term;
   logic signed [ACC_W-1:0]  i_term;
   logic signed [SUM_W-1:0]  sum;
   logic signed [SUM_W-1:0]  lim_pos;
   logic signed [SUM_W-1:0]  lim_neg;
   logic signed [SUM_W-1:0]  clamped;

   always_comb begin
      kp_s    = $signed({1'b0, kp_i});
      p_prod  = PROD_W'(kp_s) * PROD_W'(err_i);
      p_term  = p_prod >>> FRAC_W;
      i_term  = acc_i >>> FRAC_W;
      sum     = SUM_W'(ff_i) + SUM_W'(p_term) + SUM_W'(i_term);
      lim_pos = SUM_W'($signed({1'b0, lim_i}));
      lim_neg = -lim_pos;
      over_hi_o = (sum > lim_pos);
      over_lo_o = (sum < lim_neg);
      if (over_hi_o)
         clamped = lim_pos;
      else if (over_lo_o)
         clamped = lim_neg;
      else
         clamped = sum;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         drive_o <= '0;
         sat_o   <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= upd_i;
         if (upd_i) begin
            drive_o <= clamped[DATA_W-1:0];
            sat_o   <= over_hi_o || over_lo_o;
         end
      end
   end

   AST_DRIVE_IN_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> ((SUM_W'(drive_o) <= SUM_W'($signed({1'b0, $past(lim_i)}))) &&
                   (SUM_W'(drive_o) >= -SUM_W'($signed({1'b0, $past(lim_i)})))));  // R5

   AST_SAT_AT_RAIL: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && sat_o) |-> ((SUM_W'(drive_o) == SUM_W'($signed({1'b0, $past(lim_i)}))) ||
                              (SUM_W'(drive_o) == -SUM_W'($signed({1'b0, $past(lim_i)})))));  // R4

   AST_DRIVE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !upd_i |=> ($stable(drive_o) && $stable(sat_o)));                        // R11

endmodule

// File: rtl/pi_current_reg.sv
module pi_current_reg
   import pi_reg_pkg::*;
#(
   parameter int       DATA_W   = 16,
   parameter int       GAIN_W   = 16,
   parameter int       FRAC_W   = 8,
   parameter int       ACC_W    = 32,
   parameter int       HW_LIMIT = 32767,
   parameter aw_mode_e AW_MODE  = AW_COND,
   localparam int      ERR_W    = DATA_W + 1,
   localparam int      LIM_W    = DATA_W - 1
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     sample_i,
   input  logic signed [DATA_W-1:0] cmd_i,
   input  logic signed [DATA_W-1:0] meas_i,
   input  logic signed [DATA_W-1:0] ff_i,
   input  logic [GAIN_W-1:0]        kp_i,
   input  logic [GAIN_W-1:0]        ki_i,
   input  logic [LIM_W-1:0]         clamp_lim_i,
   input  logic                     freeze_i,
   output logic signed [DATA_W-1:0] drive_o,
   output logic                     sat_o,
   output logic                     valid_o
);

   // elaboration-time parameter checks
   initial begin
      AST_CFG_DATA_W: assert (DATA_W >= 4 && DATA_W <= 32)
         else $error("DATA_W out of range");
      AST_CFG_HW_LIMIT: assert (HW_LIMIT >= 1 && HW_LIMIT <= (2 ** (DATA_W - 1)) - 1)
         else $error("HW_LIMIT must fit the signed drive range");
      AST_CFG_FRAC_W: assert (FRAC_W >= 0 && FRAC_W < GAIN_W)
         else $error("FRAC_W must be below GAIN_W");
      AST_CFG_ACC_W: assert (ACC_W > FRAC_W + DATA_W && ACC_W <= 62)
         else $error("ACC_W must hold the drive range above the fraction");
   end

   logic                     s1_vld;
   logic signed [ERR_W-1:0]  s1_err;
   logic signed [DATA_W-1:0] s1_ff;
   logic [GAIN_W-1:0]        s1_kp;
   logic [GAIN_W-1:0]        s1_ki;
   logic [LIM_W-1:0]         s1_lim;
   logic                     s1_frz;
   logic signed [ACC_W-1:0]  acc;
   logic                     over_hi;
   logic                     over_lo;

   pi_sample_stage #(
      .DATA_W   (DATA_W),
      .GAIN_W   (GAIN_W),
      .HW_LIMIT (HW_LIMIT)
   ) u_sample (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .sample_i    (sample_i),
      .cmd_i       (cmd_i),
      .meas_i      (meas_i),
      .ff_i        (ff_i),
      .kp_i        (kp_i),
      .ki_i        (ki_i),
      .clamp_lim_i (clamp_lim_i),
      .freeze_i    (freeze_i),
      .s1_vld_o    (s1_vld),
      .err_o       (s1_err),
      .ff_o        (s1_ff),
      .kp_o        (s1_kp),
      .ki_o        (s1_ki),
      .lim_o       (s1_lim),
      .frz_o       (s1_frz)
   );

   pi_integrator #(
      .ERR_W   (ERR_W),
      .GAIN_W  (GAIN_W),
      .ACC_W   (ACC_W),
      .AW_MODE (AW_MODE)
   ) u_integ (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .upd_i     (s1_vld),
      .err_i     (s1_err),
      .ki_i      (s1_ki),
      .frz_i     (s1_frz),
      .over_hi_i (over_hi),
      .over_lo_i (over_lo),
      .acc_o     (acc)
   );

   pi_output_stage #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W),
      .FRAC_W (FRAC_W),
      .ACC_W  (ACC_W)
   ) u_out (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .upd_i     (s1_vld),
      .err_i     (s1_err),
      .kp_i      (s1_kp),
      .ff_i      (s1_ff),
      .lim_i     (s1_lim),
      .acc_i     (acc),
      .over_hi_o (over_hi),
      .over_lo_o (over_lo),
      .drive_o   (drive_o),
      .sat_o     (sat_o),
      .valid_o   (valid_o)
   );

   AST_VALID_TWO_CLK: assert property (@(posedge clk_i) disable iff (rst_i)
      sample_i |-> ##2 valid_o);                                               // R10

   AST_VALID_ONLY_FROM_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> $past(sample_i, 2));                                         // R10

endmodule

// File: tb/pi_current_reg_tb.sv
module pi_current_reg_tb;
   import pi_reg_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic               rst;
   logic               sample;
   logic signed [15:0] cmd, meas, ff;
   logic [15:0]        kp, ki;
   logic [14:0]        clim;
   logic               frz;
   logic signed [15:0] drv_c, drv_s;
   logic               sat_c, sat_s, vld_c, vld_s;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;
   longint m_acc [2];

   pi_current_reg #(.AW_MODE(AW_COND)) u_dut (
      .clk_i(clk), .rst_i(rst), .sample_i(sample), .cmd_i(cmd), .meas_i(meas),
      .ff_i(ff), .kp_i(kp), .ki_i(ki), .clamp_lim_i(clim), .freeze_i(frz),
      .drive_o(drv_c), .sat_o(sat_c), .valid_o(vld_c));

   pi_current_reg #(.AW_MODE(AW_STOP)) u_dut_hs (
      .clk_i(clk), .rst_i(rst), .sample_i(sample), .cmd_i(cmd), .meas_i(meas),
      .ff_i(ff), .kp_i(kp), .ki_i(ki), .clamp_lim_i(clim), .freeze_i(frz),
      .drive_o(drv_s), .sat_o(sat_s), .valid_o(vld_s));

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model of one tick from the requirements; updates model accumulator
   task automatic model(input int m, output longint d, output bit s);
      longint err, p, i, sum, lim, nxt;
      bit hold;
      err = longint'(cmd) - longint'(meas);
      p   = (longint'(kp) * err) >>> 8;
      i   = m_acc[m] >>> 8;
      sum = longint'(ff) + p + i;
      lim = (longint'(clim) < 32767) ? longint'(clim) : 32767;
      if (sum > lim) d = lim; else if (sum < -lim) d = -lim; else d = sum;
      s = (sum > lim) || (sum < -lim);
      if (m == 0) hold = frz || (sum > lim && err > 0) || (sum < -lim && err < 0);
      else        hold = frz || s;
      if (!hold) begin
         nxt = m_acc[m] + longint'(ki) * err;
         if (nxt > 64'sd2147483647) nxt = 64'sd2147483647;
         if (nxt < -64'sd2147483648) nxt = -64'sd2147483648;
         m_acc[m] = nxt;
      end
   endtask

   task automatic set_in(input int c, input int me, input int f, input int p, input int i,
                         input int l, input bit fz);
      cmd = 16'(c); meas = 16'(me); ff = 16'(f); kp = 16'(p); ki = 16'(i);
      clim = 15'(l); frz = fz;
   endtask

   // one isolated tick with latency and value checks
   task automatic tick(input string req, input int c, input int me, input int f, input int p,
                       input int i, input int l, input bit fz);
      longint e0, e1;
      bit s0, s1;
      @(negedge clk);
      set_in(c, me, f, p, i, l, fz);
      sample = 1'b1;
      model(0, e0, s0);
      model(1, e1, s1);
      @(negedge clk);
      sample = 1'b0;
      chk("R10", "valid one clock after tick", longint'(vld_c), 0);
      @(negedge clk);
      chk("R10", "valid two clocks after tick", longint'(vld_c), 1);
      chk("R12", "hard-stop valid", longint'(vld_s), 1);
      chk(req, "drive", longint'(drv_c), e0);
      chk(req, "sat", longint'(sat_c), longint'(s0));
      chk(req, "hard-stop drive", longint'(drv_s), e1);
      chk(req, "hard-stop sat", longint'(sat_s), longint'(s1));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      sample = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8", "drive in reset", longint'(drv_c), 0);
      chk("R8", "sat in reset", longint'(sat_c), 0);
      chk("R8", "valid in reset", longint'(vld_c), 0);
      rst = 1'b0;
      m_acc[0] = 0;
      m_acc[1] = 0;
   endtask

   task automatic probe(input string req);   // shows floor(acc/256) at the drive
      tick(req, 0, 0, 0, 0, 0, 32767, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      tick("R3", 100, 0, 0, 0, 256, 32767, 1'b0);
      tick("R3", 100, 0, 0, 0, 256, 32767, 1'b0);
      do_reset();
      probe("R8");     // accumulator cleared: drive 0
   endtask

   task automatic t_prop();
      do_reset();
      tick("R1", 1000, 300, 0, 256, 0, 32767, 1'b0);      // 700
      tick("R1", -500, 250, 0, 384, 0, 32767, 1'b0);      // -1125
      tick("R1", 3, 0, 0, 128, 0, 32767, 1'b0);           // floor(1.5)=1
      tick("R1", -3, 0, 0, 128, 0, 32767, 1'b0);          // floor(-1.5)=-2
   endtask

   task automatic t_ff();
      do_reset();
      tick("R2", 0, 0, -1234, 0, 0, 32767, 1'b0);
      tick("R2", 200, 100, 500, 256, 0, 32767, 1'b0);     // 600
   endtask

   task automatic t_integ();
      do_reset();
      tick("R3", 100, 0, 0, 0, 128, 32767, 1'b0);         // old acc 0 -> 0
      tick("R3", 100, 0, 0, 0, 128, 32767, 1'b0);         // 50
      tick("R3", 100, 0, 0, 0, 128, 32767, 1'b0);         // 100
      tick("R3", -300, 0, 0, 0, 128, 32767, 1'b0);
      probe("R3");
   endtask

   task automatic t_clamp();
      do_reset();
      tick("R4", 30000, -20000, 0, 256, 0, 32767, 1'b0);  // +32767 sat
      tick("R4", -30000, 20000, 0, 256, 0, 32767, 1'b0);  // -32767 sat
      tick("R4", 32767, 0, 0, 256, 0, 32767, 1'b0);       // exactly at rail, not sat
      tick("R5", 30000, 0, 0, 256, 0, 1000, 1'b0);        // derated to 1000
      tick("R5", -900, 0, 0, 256, 0, 1000, 1'b0);         // inside: -900
      tick("R5", 5, 0, 0, 256, 0, 0, 1'b0);               // limit 0 -> 0 sat
   endtask

   task automatic t_windup();
      do_reset();
      for (int k = 0; k < 3; k++) tick("R6", 1000, 0, 0, 256, 256, 500, 1'b0);
      probe("R6");                                         // no windup: 0
      for (int k = 0; k < 2; k++) tick("R6", -100, 0, 2000, 0, 256, 500, 1'b0);
      probe("R6");                                         // release integrated: -200
      tick("R12", -100, 0, -2000, 0, 256, 500, 1'b0);      // below rail, negative error
      probe("R12");
   endtask

   task automatic t_freeze();
      do_reset();
      tick("R7", 400, 0, 0, 0, 256, 32767, 1'b0);
      for (int k = 0; k < 3; k++) tick("R7", 1000, 0, 0, 0, 256, 32767, 1'b1);
      probe("R7");                                         // 400 only
   endtask

   task automatic t_acc_sat();
      do_reset();
      tick("R9", 32767, -32768, 0, 0, 65535, 32767, 1'b0);
      probe("R9");                                         // +32767, wrap would be -512
      do_reset();
      tick("R9", -32768, 32767, 0, 0, 65535, 32767, 1'b0);
      probe("R9");                                         // -32767, wrap would be 511
   endtask

   task automatic t_b2b();
      longint e [3];
      bit s [3];
      longint dummy;
      bit ds;
      do_reset();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         set_in(100 * (k + 1), 0, 10 * k, 256, 256, 32767, 1'b0);
         sample = 1'b1;
         model(0, e[k], s[k]);
         model(1, dummy, ds);
         if (k >= 2) chk("R10", "b2b valid", longint'(vld_c), 1);
         if (k == 2) chk("R10", "b2b drive 0", longint'(drv_c), e[0]);
      end
      @(negedge clk);
      sample = 1'b0;
      chk("R10", "b2b drive 1", longint'(drv_c), e[1]);
      @(negedge clk);
      chk("R10", "b2b drive 2", longint'(drv_c), e[2]);
      chk("R10", "b2b valid last", longint'(vld_c), 1);
      @(negedge clk);
      chk("R10", "valid drops", longint'(vld_c), 0);
      // inputs move with no tick: outputs and state hold
      for (int k = 0; k < 4; k++) begin
         set_in(-20000, 5000, 3000, 999, 999, 7, k[0]);
         @(negedge clk);
         chk("R11", "drive held", longint'(drv_c), e[2]);
         chk("R11", "no valid", longint'(vld_c), 0);
      end
      probe("R11");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      sample = 1'b0;
      set_in(0, 0, 0, 0, 0, 32767, 1'b0);
      m_acc[0] = 0;
      m_acc[1] = 0;
      repeat (4) @(negedge clk);
      chk("R8", "drive at reset", longint'(drv_c), 0);
      chk("R8", "valid at reset", longint'(vld_c), 0);
      rst = 1'b0;
      t_reset();
      t_prop();
      t_ff();
      t_integ();
      t_clamp();
      t_windup();
      t_freeze();
      t_acc_sat();
      t_b2b();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule